// File: doc/BRIEF.md
# SPI Master Frame Timing Sequencer

This block is the timing engine of a serial peripheral master. It derives the serial clock from the system clock through a coded prescaler, a coded scaler and a rate-doubling option. It walks every frame through a fixed sequence: select asserted, a programmable lead time, a burst of serial clock pulses, a programmable trail time, select released, and a programmable idle gap. The data path that shifts bits in and out is outside the block. It follows the shift strobe, which marks the start of each bit's clock pulse.

A client holds `frame_req` high with the timing codes and the frame length on the inputs. The sequencer copies all of them into an internal snapshot in the cycle it accepts the frame. It signals that cycle with a one-cycle `frame_ack`. If `frame_req` is still high when the idle gap ends, the next frame starts at once with a fresh snapshot. If it is low, the block returns to idle. In continuous mode the idle gap is one serial clock period, whatever the gap codes say.

Top module: `spi_frame_seq`

## Requirements
- R1: While reset is applied and in the first cycles after it is released, `cs_n` is 1 and `sck`, `shift_stb` and `frame_ack` are 0.
- R2: With `dbr`=0, the serial clock period is B cycles and the high phase is B/2 cycles. B is the baud prescaler times the baud scaler. `br_pre` codes 0,1,2,3 select 2,3,5,7. `br_scl` codes 0,1,2 select 2,4,6, and a code n of 3 or more selects 2^(n+1).
- R3: With `dbr`=1, the period is P=B/2 cycles. The high phase is floor(P/2) cycles and the low phase is P-floor(P/2) cycles.
- R4: The count of cycles from `cs_n` falling to the first `sck` rise equals the lead prescaler times the lead scaler. Prescaler codes 0,1,2,3 select 1,3,5,7. A 4-bit scaler code n selects 2^(n+1).
- R5: The count of cycles from the last `sck` fall to `cs_n` rising equals the trail prescaler times the trail scaler, using the same tables as R4.
- R6: With `cont_mode`=0 and `frame_req` held, the count of cycles from `cs_n` rising to the next `cs_n` fall equals the gap prescaler times the gap scaler, using the same tables as R4.
- R7: With `cont_mode`=1, that inter-frame gap equals one serial clock period as defined in R2/R3, and the gap codes have no effect.
- R8: A frame has exactly `frame_len_m1`+1 rising edges of `sck`. `shift_stb` pulses for one cycle in the first cycle of each high phase, and at no other time.
- R9: All timing codes and the frame length are captured when the frame is accepted. Changes to them during the frame have no effect on that frame.
- R10: `frame_ack` is a one-cycle pulse in the first cycle of each frame in which `cs_n` is low, once per frame. When `frame_req` is low at the end of the gap, `cs_n` stays high and no further frame starts.
- R11: `sck` is 0 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_req | input | 1 | Request to start or continue frames |
| frame_len_m1 | input | 5 | Frame length in bits minus one |
| cont_mode | input | 1 | Gap of one serial clock period when 1 |
| dbr | input | 1 | Doubles the serial clock rate |
| br_pre | input | 2 | Baud prescaler code |
| br_scl | input | 4 | Baud scaler code |
| csc_pre | input | 2 | Lead delay prescaler code |
| csc_scl | input | 4 | Lead delay scaler code |
| asc_pre | input | 2 | Trail delay prescaler code |
| asc_scl | input | 4 | Trail delay scaler code |
| dt_pre | input | 2 | Gap delay prescaler code |
| dt_scl | input | 4 | Gap delay scaler code |
| frame_ack | output | 1 | Frame accepted pulse |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles low |
| shift_stb | output | 1 | One-cycle pulse at each serial clock rise |

## Verification
The hardest case to reach from the ports is a change of timing codes while a frame is running. The snapshot hides the new codes until the next acceptance, so only timing measurements can show whether the snapshot worked. The stimulus rewrites every code and the length on the falling clock edge right after `frame_ack` is seen. It measures that frame against the old values and the next one against the new values. A second hard case is the long gap: a scaler code of 14 is held across two back-to-back frames, and the bench measures the gap of nearly a hundred thousand cycles between them exactly.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;
  parameter int unsigned PRE_W = 2;
  parameter int unsigned SCL_W = 4;
  parameter int unsigned LEN_W = 5;
  // largest product: 7 * 2^(2^SCL_W)
  parameter int unsigned CNT_W = (1 << SCL_W) + 3;
  parameter int unsigned N_DLY = 3;

  typedef logic [CNT_W-1:0] cyc_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic             cont;
    logic             dbr;
    logic [PRE_W-1:0] br_pre;
    logic [SCL_W-1:0] br_scl;
    logic [PRE_W-1:0] csc_pre;
    logic [SCL_W-1:0] csc_scl;
    logic [PRE_W-1:0] asc_pre;
    logic [SCL_W-1:0] asc_scl;
    logic [PRE_W-1:0] dt_pre;
    logic [SCL_W-1:0] dt_scl;
  } tmg_cfg_t;
endpackage

// File: rtl/spi_tmg_dly_dec.sv
module spi_tmg_dly_dec
  import spi_tmg_pkg::*;
#(
  parameter bit BAUD = 1'b0
) (
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  output cyc_t             cycles
);
  logic [2:0] pre_v;
  cyc_t       scl_v;

  generate
    if (BAUD) begin : g_baud
      always_comb begin
        case (pre_code)
          2'd0:    pre_v = 3'd2;
          2'd1:    pre_v = 3'd3;
          2'd2:    pre_v = 3'd5;
          default: pre_v = 3'd7;
        endcase
        case (scl_code)
          4'd0:    scl_v = cyc_t'(2);
          4'd1:    scl_v = cyc_t'(4);
          4'd2:    scl_v = cyc_t'(6);
          default: scl_v = cyc_t'(2) << scl_code;
        endcase
      end
    end else begin : g_delay
      always_comb begin
        case (pre_code)
          2'd0:    pre_v = 3'd1;
          2'd1:    pre_v = 3'd3;
          2'd2:    pre_v = 3'd5;
          default: pre_v = 3'd7;
        endcase
        scl_v = cyc_t'(2) << scl_code;
      end
    end
  endgenerate

  assign cycles = cyc_t'(pre_v) * scl_v;
endmodule

// File: rtl/spi_tmg_half_calc.sv
module spi_tmg_half_calc
  import spi_tmg_pkg::*;
(
  input  cyc_t baud_div,
  input  logic dbl,
  output cyc_t period,
  output cyc_t hi_len,
  output cyc_t lo_len
);
  always_comb begin
    period = dbl ? (baud_div >> 1) : baud_div;
    hi_len = period >> 1;
    lo_len = period - hi_len;
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_tmg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_req,
  input  logic [LEN_W-1:0] frame_len_m1,
  input  logic             cont_mode,
  input  logic             dbr,
  input  logic [PRE_W-1:0] br_pre,
  input  logic [SCL_W-1:0] br_scl,
  input  logic [PRE_W-1:0] csc_pre,
  input  logic [SCL_W-1:0] csc_scl,
  input  logic [PRE_W-1:0] asc_pre,
  input  logic [SCL_W-1:0] asc_scl,
  input  logic [PRE_W-1:0] dt_pre,
  input  logic [SCL_W-1:0] dt_scl,
  output logic             frame_ack,
  output logic             cs_n,
  output logic             sck,
  output logic             shift_stb
);
  localparam cyc_t ONE = cyc_t'(1);
  localparam int unsigned D_LEAD  = 0;
  localparam int unsigned D_TRAIL = 1;
  localparam int unsigned D_GAP   = 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  seq_st_e          st_q, st_d;
  cyc_t             cnt_q, cnt_d;
  logic [LEN_W-1:0] bit_q, bit_d;
  logic             sck_q, sck_d;
  logic             stb_q, stb_d;
  logic             ack_q, ack_d;
  logic             csn_q, csn_d;
  tmg_cfg_t         cfg_q, cfg_d;
  tmg_cfg_t         cfg_in;

  assign cfg_in = '{len_m1: frame_len_m1, cont: cont_mode, dbr: dbr,
                    br_pre: br_pre, br_scl: br_scl,
                    csc_pre: csc_pre, csc_scl: csc_scl,
                    asc_pre: asc_pre, asc_scl: asc_scl,
                    dt_pre: dt_pre, dt_scl: dt_scl};

  // decode from the captured snapshot
  logic [PRE_W-1:0] dly_pre [N_DLY];
  logic [SCL_W-1:0] dly_scl [N_DLY];
  cyc_t             dly_len [N_DLY];

  assign dly_pre[D_LEAD]  = cfg_q.csc_pre;
  assign dly_scl[D_LEAD]  = cfg_q.csc_scl;
  assign dly_pre[D_TRAIL] = cfg_q.asc_pre;
  assign dly_scl[D_TRAIL] = cfg_q.asc_scl;
  assign dly_pre[D_GAP]   = cfg_q.dt_pre;
  assign dly_scl[D_GAP]   = cfg_q.dt_scl;

  generate
    for (genvar gi = 0; gi < N_DLY; gi++) begin : g_dly
      spi_tmg_dly_dec #(.BAUD(1'b0)) dec_i (
        .pre_code (dly_pre[gi]),
        .scl_code (dly_scl[gi]),
        .cycles   (dly_len[gi])
      );
    end
  endgenerate

  cyc_t baud_div, sck_per, sck_hi, sck_lo, gap_len;

  spi_tmg_dly_dec #(.BAUD(1'b1)) baud_dec_i (
    .pre_code (cfg_q.br_pre),
    .scl_code (cfg_q.br_scl),
    .cycles   (baud_div)
  );

  spi_tmg_half_calc half_i (
    .baud_div (baud_div),
    .dbl      (cfg_q.dbr),
    .period   (sck_per),
    .hi_len   (sck_hi),
    .lo_len   (sck_lo)
  );

  assign gap_len = cfg_q.cont ? sck_per : dly_len[D_GAP];

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sck_d = sck_q;
    csn_d = csn_q;
    cfg_d = cfg_q;
    stb_d = 1'b0;
    ack_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (frame_req) begin
          st_d  = ST_LEAD;
          cfg_d = cfg_in;
          csn_d = 1'b0;
          ack_d = 1'b1;
          cnt_d = '0;
        end
      end
      ST_LEAD: begin
        if (cnt_q == dly_len[D_LEAD] - ONE) begin
          st_d  = ST_SHIFT;
          sck_d = 1'b1;
          stb_d = 1'b1;
          bit_d = '0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_SHIFT: begin
        if (sck_q) begin
          if (cnt_q == sck_hi - ONE) begin
            sck_d = 1'b0;
            cnt_d = '0;
            if (bit_q == cfg_q.len_m1) st_d = ST_TRAIL;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == sck_lo - ONE) begin
            sck_d = 1'b1;
            stb_d = 1'b1;
            cnt_d = '0;
            bit_d = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      ST_TRAIL: begin
        if (cnt_q == dly_len[D_TRAIL] - ONE) begin
          st_d  = ST_GAP;
          csn_d = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      ST_GAP: begin
        if (cnt_q == gap_len - ONE) begin
          cnt_d = '0;
          if (frame_req) begin
            st_d  = ST_LEAD;
            cfg_d = cfg_in;
            csn_d = 1'b0;
            ack_d = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
      stb_q <= 1'b0;
      ack_q <= 1'b0;
      csn_q <= 1'b1;
      cfg_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sck_q <= sck_d;
      stb_q <= stb_d;
      ack_q <= ack_d;
      csn_q <= csn_d;
      cfg_q <= cfg_d;
    end
  end

  assign frame_ack = ack_q;
  assign cs_n      = csn_q;
  assign sck       = sck_q;
  assign shift_stb = stb_q;
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk
  import spi_tmg_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     cs_n,
  input logic     sck,
  input logic     shift_stb,
  input logic     frame_ack,
  input tmg_cfg_t cfg
);
  // R11
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R8
  stb_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (sck && !$past(sck)));

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ack |=> !frame_ack);

  // R10
  ack_with_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ack |-> $fell(cs_n));

  // R5
  release_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sck && !$past(sck)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !frame_ack) |-> $stable(cfg));
endmodule

bind spi_frame_seq spi_frame_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sck       (sck),
  .shift_stb (shift_stb),
  .frame_ack (frame_ack),
  .cfg       (cfg_q)
);

// File: tb/spi_frame_seq_tb_top.sv
module spi_frame_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       frame_req;
  logic [4:0] frame_len_m1;
  logic       cont_mode, dbr;
  logic [1:0] br_pre, csc_pre, asc_pre, dt_pre;
  logic [3:0] br_scl, csc_scl, asc_scl, dt_scl;
  logic       frame_ack, cs_n, sck, shift_stb;

  int n_vec = 0;
  int n_bad = 0;
  longint cyc = 0;
  localparam longint WDOG = 190000;

  spi_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_len_m1(frame_len_m1),
    .cont_mode(cont_mode), .dbr(dbr), .br_pre(br_pre), .br_scl(br_scl),
    .csc_pre(csc_pre), .csc_scl(csc_scl), .asc_pre(asc_pre), .asc_scl(asc_scl),
    .dt_pre(dt_pre), .dt_scl(dt_scl), .frame_ack(frame_ack), .cs_n(cs_n),
    .sck(sck), .shift_stb(shift_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // measurement results
  longint m_csf, m_csr, m_r0, m_r1, m_f0, m_flast;
  int m_nrise, m_nstb, m_stb_bad, m_nack;

  function automatic longint dly(input int p, input int s);
    int pv[4] = '{1, 3, 5, 7};
    return longint'(pv[p]) * (longint'(2) << s);
  endfunction

  function automatic longint bdiv(input int p, input int s);
    int pv[4] = '{2, 3, 5, 7};
    longint sv;
    sv = (s < 3) ? longint'(2 * (s + 1)) : (longint'(2) << s);
    return longint'(pv[p]) * sv;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int len, input bit c, input bit d,
                         input int bp, input int bs, input int cp, input int cs,
                         input int ap, input int as_, input int gp, input int gs);
    frame_len_m1 = 5'(len - 1);
    cont_mode = c; dbr = d;
    br_pre = 2'(bp);  br_scl = 4'(bs);
    csc_pre = 2'(cp); csc_scl = 4'(cs);
    asc_pre = 2'(ap); asc_scl = 4'(as_);
    dt_pre = 2'(gp);  dt_scl = 4'(gs);
  endtask

  // records one frame; drops request at ack unless keep; mutate alters inputs at ack
  task automatic measure(input bit keep, input bit mutate);
    bit started = 1'b0;
    bit psck = 1'b0;
    m_nrise = 0; m_nstb = 0; m_stb_bad = 0; m_nack = 0;
    frame_req = 1'b1;
    forever begin
      @(negedge clk);
      if (frame_ack) begin
        m_nack++;
        if (!keep) frame_req = 1'b0;
        if (mutate) set_cfg(11, 1'b0, 1'b1, 3, 3, 3, 3, 3, 3, 3, 3);
      end
      if (!started) begin
        if (!cs_n) begin started = 1'b1; m_csf = cyc; end
      end else if (cs_n) begin
        m_csr = cyc;
        break;
      end
      if (started) begin
        if (sck && !psck) begin
          if (m_nrise == 0) m_r0 = cyc;
          if (m_nrise == 1) m_r1 = cyc;
          m_nrise++;
        end
        if (!sck && psck) begin
          if (m_nrise == 1) m_f0 = cyc;
          m_flast = cyc;
        end
        if (shift_stb) begin
          m_nstb++;
          if (!(sck && !psck)) m_stb_bad++;
        end
      end
      psck = sck;
    end
  endtask

  task automatic check_frame(input string ptag, input longint e_csc, input longint e_per,
                             input longint e_hi, input longint e_asc, input int e_bits);
    chk("R4 lead delay", m_r0 - m_csf, e_csc);
    chk({ptag, " period"}, m_r1 - m_r0, e_per);
    chk({ptag, " high phase"}, m_f0 - m_r0, e_hi);
    chk("R5 trail delay", m_csr - m_flast, e_asc);
    chk("R8 rising edges", m_nrise, e_bits);
    chk("R8 strobe count", m_nstb, e_bits);
    chk("R8 strobe placement", m_stb_bad, 0);
    chk("R10 one ack per frame", m_nack, 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; frame_req = 1'b0;
    set_cfg(4, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R1 cs_n in reset", cs_n, 1);
    chk("R1 sck in reset", sck, 0);
    chk("R1 strobe in reset", shift_stb, 0);
    chk("R1 ack in reset", frame_ack, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs_n after reset", cs_n, 1);
    chk("R1 sck after reset", sck, 0);
  endtask

  task automatic t_basic;
    // R2: B=4, high 2; lead 2, trail 6, 4 bits
    set_cfg(4, 1'b0, 1'b0, 0, 0, 0, 0, 1, 0, 0, 0);
    measure(1'b0, 1'b0);
    check_frame("R2", dly(0,0), 4, 2, dly(1,0), 4);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_double_odd;
    // R3: B=6, P=3, high 1
    set_cfg(8, 1'b0, 1'b1, 1, 0, 1, 2, 2, 1, 0, 0);
    measure(1'b0, 1'b0);
    check_frame("R3", 24, 3, 1, 20, 8);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_scalers;
    // R2: prescaler 5, scaler code 2 -> 30
    set_cfg(2, 1'b0, 1'b0, 2, 2, 3, 0, 0, 3, 0, 0);
    measure(1'b0, 1'b0);
    check_frame("R2", 14, bdiv(2,2), 15, 16, 2);
    repeat (20) @(negedge clk);
    // R3: prescaler 7, scaler 16 -> 112, halved 56; lead/trail 96
    set_cfg(3, 1'b0, 1'b1, 3, 3, 1, 4, 1, 4, 0, 0);
    measure(1'b0, 1'b0);
    check_frame("R3", 96, 56, 28, 96, 3);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_gap(input int gp, input int gs);
    longint first_csr;
    // R6: two frames back to back
    set_cfg(2, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, gp, gs);
    measure(1'b1, 1'b0);
    first_csr = m_csr;
    measure(1'b0, 1'b0);
    chk("R6 programmed gap", m_csf - first_csr, dly(gp, gs));
    chk("R6 second frame bits", m_nrise, 2);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_cont;
    longint first_csr;
    // R7: gap codes would give 96, expect one period of 12
    set_cfg(3, 1'b1, 1'b0, 1, 1, 0, 0, 0, 0, 1, 4);
    measure(1'b1, 1'b0);
    first_csr = m_csr;
    chk("R7 period", m_r1 - m_r0, bdiv(1,1));
    measure(1'b0, 1'b0);
    chk("R7 continuous gap", m_csf - first_csr, 12);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_snapshot;
    // R9: inputs rewritten right after ack
    set_cfg(4, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    measure(1'b0, 1'b1);
    check_frame("R9", 2, 4, 2, 2, 4);
    repeat (20) @(negedge clk);
    measure(1'b0, 1'b0);
    chk("R9 new lead", m_r0 - m_csf, dly(3,3));
    chk("R9 new period", m_r1 - m_r0, bdiv(3,3) / 2);
    chk("R9 new trail", m_csr - m_flast, dly(3,3));
    chk("R9 new length", m_nrise, 11);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_idle;
    int acks = 0;
    int lows = 0;
    // R10: request low after frame -> stays idle
    set_cfg(2, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    measure(1'b0, 1'b0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (frame_ack) acks++;
      if (!cs_n || sck) lows++;
    end
    chk("R10 no further ack", acks, 0);
    chk("R10 select stays high", lows, 0);
  endtask

  initial begin
    frame_req = 1'b0;
    t_reset();
    t_basic();
    t_double_odd();
    t_scalers();
    t_gap(3, 1);
    t_cont();
    t_snapshot();
    t_idle();
    t_gap(1, 14);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule